// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer

This block paces instruction flow for a small 8-bit controller core. It turns the system clock into a rotating set of four one-hot phase strobes; one full turn of the strobes is one instruction cycle. Across that cycle the block presents a program-memory address, captures the returned instruction word, and hands the word to the execute stage during the following instruction cycle. The next instruction is therefore fetched while the current one executes.

The decoder uses the phase strobes to time its own work and reports program-counter changes, such as jumps and calls, with a request and a target address. The block samples the request only in the last phase and only when the instruction being executed is valid. It then redirects the fetch address and marks the sequentially fetched word as not to be executed. Every taken branch therefore costs exactly one bubble cycle. The ALU, the data memory and the decode itself sit outside this block.

Top module: `pipe_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters its idle state: `phase_t` = 4'b0001 (T1), `fetch_addr` = 0, `instr_reg` = 0 and `exec_valid` = 0.
- R2: Bit 0 of `phase_t` is T1, bit 1 is T2, bit 2 is T3 and bit 3 is T4. Outside reset, exactly one bit is high, and the active bit advances T1→T2→T3→T4→T1 on every clock.
- R3: `fetch_addr` holds one value for all four phases of an instruction cycle. It changes only on the edge that moves `phase_t` from T4 to T1.
- R4: If no branch is taken, `fetch_addr` rises by one on each instruction cycle and wraps from 2^PC_W−1 to 0.
- R5: `instr_reg` and `exec_valid` change only on the T4→T1 edge, and they stay constant through T1 to T4.
- R6: The first instruction cycle after reset has `exec_valid` = 0. Each later cycle that does not follow a taken branch has `exec_valid` = 1, and in such a cycle `instr_reg` holds the word that was read at the previous cycle's `fetch_addr`.
- R7: A branch is taken when `br_req` is high at the T4 edge while `exec_valid` = 1. In the next instruction cycle, `fetch_addr` equals the sampled `br_target` and `exec_valid` = 0.
- R8: In the instruction cycle after that bubble, `exec_valid` = 1 and `instr_reg` holds the word read at the branch target.
- R9: `br_req` and `br_target` have no effect in T1, T2 or T3. They also have no effect at T4 when `exec_valid` = 0; in that case the fetch continues sequentially.
- R10: `instr_in` is captured only at the T4 edge. Its value in T1 to T3 never reaches `instr_reg`.

Parameters: `INSTR_W` sets the width of the instruction word (default 16). `PC_W` sets the width of the program counter (default 11). `PHASE_RING` selects how the phase state is held (default 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_in | input | INSTR_W | Word returned by program memory for `fetch_addr` |
| br_req | input | 1 | Decoder asks to load a new program counter |
| br_target | input | PC_W | Program counter value to load when the branch is taken |
| phase_t | output | 4 | One-hot phase strobes; bit 0 is T1 and bit 3 is T4 |
| fetch_addr | output | PC_W | Program-memory address for the current instruction cycle |
| instr_reg | output | INSTR_W | Instruction being executed in this instruction cycle |
| exec_valid | output | 1 | `instr_reg` is to be executed in this cycle |

## Verification
The hardest case to reach is a branch request that arrives while the pipeline is already in a bubble, because the request then has to be ignored and the fetch must carry on sequentially. The stimulus reaches this case by issuing a second branch request in the cycle directly after a taken branch. The bench also asserts `br_req` with a decoy target throughout T1 to T3. It presents a corrupted instruction word in every phase except T4, so any capture or branch sampled at the wrong phase shows up in `instr_reg` or `fetch_addr`. A jump to the top two addresses then lets the sequential fetch wrap to zero.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int unsigned NUM_PHASES = 4;

    typedef logic [NUM_PHASES-1:0] phase_vec_t;

    localparam phase_vec_t PH_FIRST = phase_vec_t'(1);

    // Next strobe pattern: the active phase moves one place towards T4, and T4 wraps to T1.
    function automatic phase_vec_t phase_advance(input phase_vec_t cur);
        return {cur[NUM_PHASES-2:0], cur[NUM_PHASES-1]};
    endfunction

endpackage

// File: rtl/seq_phase_gen.sv
module seq_phase_gen
    import seq_pkg::*;
#(
    parameter bit RING = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    output phase_vec_t phase_o,
    output logic       last_o
);

    generate
        if (RING) begin : g_ring
            // The phase is held directly as a one-hot ring of flops.
            typedef struct packed {
                phase_vec_t ring;
            } ring_st_t;

            ring_st_t s_d, s_q;

            always_comb begin
                s_d      = s_q;
                s_d.ring = phase_advance(s_q.ring);
                if (rst) begin
                    s_d.ring = PH_FIRST;
                end
            end

            always_ff @(posedge clk) begin
                s_q <= s_d;
            end

            assign phase_o = s_q.ring;
        end else begin : g_count
            // The phase is held as a binary count and decoded to strobes.
            localparam int unsigned CNT_W = $clog2(NUM_PHASES);
            localparam logic [CNT_W-1:0] CNT_ONE = 1;

            typedef struct packed {
                logic [CNT_W-1:0] cnt;
            } cnt_st_t;

            cnt_st_t s_d, s_q;

            always_comb begin
                s_d     = s_q;
                s_d.cnt = s_q.cnt + CNT_ONE;
                if (rst) begin
                    s_d.cnt = '0;
                end
            end

            always_ff @(posedge clk) begin
                s_q <= s_d;
            end

            assign phase_o = PH_FIRST << s_q.cnt;
        end
    endgenerate

    assign last_o = phase_o[NUM_PHASES-1];

    assert_phase_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_o) == 1);

    assert_phase_rotate_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase_o == phase_advance($past(phase_o)));

endmodule

// File: rtl/seq_pc_unit.sv
module seq_pc_unit #(
    parameter int unsigned PC_W = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            last_i,
    input  logic            br_req_i,
    input  logic [PC_W-1:0] br_target_i,
    input  logic            exec_valid_i,
    output logic [PC_W-1:0] pc_o,
    output logic            take_o
);

    localparam logic [PC_W-1:0] PC_ONE = 1;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_st_t;

    pc_st_t s_d, s_q;

    // A request counts only at the closing phase, and only for an instruction that really executes.
    assign take_o = last_i & br_req_i & exec_valid_i;

    always_comb begin
        s_d = s_q;
        if (last_i) begin
            s_d.pc = take_o ? br_target_i : (s_q.pc + PC_ONE);
        end
        if (rst) begin
            s_d.pc = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign pc_o = s_q.pc;

    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !last_i |=> $stable(pc_o));

    assert_pc_step_R4: assert property (@(posedge clk) disable iff (rst)
        (last_i && !take_o) |=> pc_o == $past(pc_o) + PC_ONE);

    assert_pc_branch_R7: assert property (@(posedge clk) disable iff (rst)
        take_o |=> pc_o == $past(br_target_i));

endmodule

// File: rtl/seq_ir_stage.sv
module seq_ir_stage #(
    parameter int unsigned INSTR_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               last_i,
    input  logic               take_i,
    input  logic [INSTR_W-1:0] instr_i,
    output logic [INSTR_W-1:0] ir_o,
    output logic               valid_o
);

    typedef struct packed {
        logic [INSTR_W-1:0] ir;
        logic               valid;
    } ir_st_t;

    ir_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (last_i) begin
            // The word fetched behind a taken branch is loaded but flagged so it does not execute.
            s_d.ir    = instr_i;
            s_d.valid = !take_i;
        end
        if (rst) begin
            s_d.ir    = '0;
            s_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign ir_o    = s_q.ir;
    assign valid_o = s_q.valid;

    assert_ir_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !last_i |=> ($stable(ir_o) && $stable(valid_o)));

    assert_flush_after_branch_R7: assert property (@(posedge clk) disable iff (rst)
        take_i |=> !valid_o);

endmodule

// File: rtl/pipe_sequencer.sv
module pipe_sequencer
    import seq_pkg::*;
#(
    parameter int unsigned INSTR_W    = 16,
    parameter int unsigned PC_W       = 11,
    parameter bit          PHASE_RING = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr_in,
    input  logic               br_req,
    input  logic [PC_W-1:0]    br_target,
    output logic [3:0]         phase_t,
    output logic [PC_W-1:0]    fetch_addr,
    output logic [INSTR_W-1:0] instr_reg,
    output logic               exec_valid
);

    localparam logic [PC_W-1:0] ADDR_ONE = 1;

    phase_vec_t phase_w;
    logic       last_w;
    logic       take_w;

    seq_phase_gen #(
        .RING (PHASE_RING)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase_w),
        .last_o  (last_w)
    );

    seq_pc_unit #(
        .PC_W (PC_W)
    ) u_pc (
        .clk          (clk),
        .rst          (rst),
        .last_i       (last_w),
        .br_req_i     (br_req),
        .br_target_i  (br_target),
        .exec_valid_i (exec_valid),
        .pc_o         (fetch_addr),
        .take_o       (take_w)
    );

    seq_ir_stage #(
        .INSTR_W (INSTR_W)
    ) u_ir (
        .clk     (clk),
        .rst     (rst),
        .last_i  (last_w),
        .take_i  (take_w),
        .instr_i (instr_in),
        .ir_o    (instr_reg),
        .valid_o (exec_valid)
    );

    assign phase_t = phase_w;

    // A request that arrives during a bubble must leave the fetch on its sequential path.
    assert_bubble_ignores_branch_R9: assert property (@(posedge clk) disable iff (rst)
        (phase_t[3] && br_req && !exec_valid) |=> fetch_addr == $past(fetch_addr) + ADDR_ONE);

    assert_refill_after_bubble_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_t[3] && !exec_valid) |=> exec_valid);

endmodule

// File: tb/sim_pipe_sequencer.sv
module sim_pipe_sequencer;

    localparam int CLK_P   = 10;
    localparam int PC_W    = 11;
    localparam int INSTR_W = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [INSTR_W-1:0] instr_in;
    logic               br_req = 1'b0;
    logic [PC_W-1:0]    br_target = '0;
    logic [3:0]         phase_t;
    logic [PC_W-1:0]    fetch_addr;
    logic [INSTR_W-1:0] instr_reg;
    logic               exec_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit mon_on  = 1'b0;

    typedef struct {
        logic [PC_W-1:0]    pc;
        logic [INSTR_W-1:0] ir;
        logic               valid;
    } item_t;

    item_t sb_q[$];

    logic [PC_W-1:0]    e_pc;
    logic [INSTR_W-1:0] e_ir;
    logic               e_valid;

    always #(CLK_P/2) clk = ~clk;

    pipe_sequencer #(.INSTR_W(INSTR_W), .PC_W(PC_W)) u0 (
        .clk        (clk),
        .rst        (rst),
        .instr_in   (instr_in),
        .br_req     (br_req),
        .br_target  (br_target),
        .phase_t    (phase_t),
        .fetch_addr (fetch_addr),
        .instr_reg  (instr_reg),
        .exec_valid (exec_valid)
    );

    function automatic logic [INSTR_W-1:0] mem_word(input logic [PC_W-1:0] a);
        return (INSTR_W'(a) * 16'h9E37) ^ 16'hC3A5;
    endfunction

    // Program memory model: the true word at T4, a corrupted one in other phases (R10).
    always_comb instr_in = phase_t[3] ? mem_word(fetch_addr) : ~mem_word(fetch_addr);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: called at the falling edge inside T1; runs one instruction cycle.
    task automatic run_cycle(input bit br, input logic [PC_W-1:0] tgt, input bit decoy);
        item_t it;
        it.pc = e_pc; it.ir = e_ir; it.valid = e_valid;
        sb_q.push_back(it);
        br_req    = decoy;
        br_target = ~tgt;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        br_req    = br;
        br_target = tgt;
        if (br && e_valid) begin
            e_ir = mem_word(e_pc); e_pc = tgt; e_valid = 1'b0;
        end else begin
            e_ir = mem_word(e_pc); e_pc = e_pc + 1'b1; e_valid = 1'b1;
        end
        @(negedge clk);
        br_req = 1'b0;
    endtask

    // Monitor: checks the phase rotation every clock and the scoreboard item in T2..T4.
    initial begin
        logic [3:0] prev_ph;
        bit         prev_ok;
        prev_ok = 1'b0;
        prev_ph = '0;
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (rst || !mon_on) begin
                prev_ok = 1'b0;
            end else begin
                if (prev_ok)
                    check("R2 phase rotation", 32'(phase_t), 32'({prev_ph[2:0], prev_ph[3]}));
                prev_ph = phase_t;
                prev_ok = 1'b1;
                if (phase_t[3:1] != 3'b000) begin
                    if (sb_q.size() == 0) begin
                        check("R5 scoreboard underrun", 32'd0, 32'd1);
                    end else begin
                        check("R3,R4,R7,R9 fetch_addr", 32'(fetch_addr), 32'(sb_q[0].pc));
                        check("R5,R6,R7,R8 exec_valid", 32'(exec_valid), 32'(sb_q[0].valid));
                        if (sb_q[0].valid)
                            check("R5,R6,R8,R10 instr_reg", 32'(instr_reg), 32'(sb_q[0].ir));
                        if (phase_t[3]) void'(sb_q.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 phase", 32'(phase_t), 32'h1);
        check("R1 fetch_addr", 32'(fetch_addr), 32'h0);
        check("R1 instr_reg", 32'(instr_reg), 32'h0);
        check("R1 exec_valid", 32'(exec_valid), 32'h0);
        e_pc = '0; e_ir = '0; e_valid = 1'b0;
        rst = 1'b0;
        mon_on = 1'b1;
        repeat (4) run_cycle(1'b0, '0, 1'b0);
        // R9: decoy requests in T1..T3 only
        repeat (2) run_cycle(1'b0, 11'h055, 1'b1);
        // R7: taken branch, then R9: a request during the bubble is ignored
        run_cycle(1'b1, 11'h100, 1'b0);
        run_cycle(1'b1, 11'h300, 1'b0);
        repeat (3) run_cycle(1'b0, '0, 1'b0);
        // R8: branch, bubble, then a branch right after refill
        run_cycle(1'b1, 11'h200, 1'b0);
        run_cycle(1'b0, '0, 1'b0);
        run_cycle(1'b1, 11'h210, 1'b0);
        repeat (2) run_cycle(1'b0, '0, 1'b0);
        // R4: wrap past the top of the address space
        run_cycle(1'b1, 11'h7FE, 1'b0);
        repeat (5) run_cycle(1'b0, '0, 1'b0);
        mon_on = 1'b0;
        check("R6 scoreboard drained", 32'(sb_q.size()), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule